// File: doc/BRIEF.md
# Serial Channel Event and Interrupt Mask Unit

This block gathers status events from an asynchronous serial channel and turns them into one interrupt request. The receiver side reports a break, a captured control character, a character dropped because no receive buffer was free, and a closed receive buffer. The transmitter side reports a finished transmit buffer. Each event is held in a sticky event register until software clears it. A mask register of the same layout chooses which events may raise the interrupt.

Each event is set at a defined point in the character's bit timing. Receive-side decisions are taken on the mid-stop-bit strobe. If no buffer is free at that strobe, the character is dropped and flagged as busy. If a buffer is free and the character closes it, the buffer-done event is set. A per-buffer mode bit picks one of two moments for the transmit-done event. In immediate mode it is set when the final character is written into the transmit FIFO. In deferred mode it waits for the start of that character's last data bit on the line. A busy condition in multidrop mode also sends the receiver straight back to address hunting.

Software reaches both registers through a small read/write port. Address 0 is the event register, which is write-one-to-clear. Address 1 is the mask register, which is plain read/write.

Top module: `uart_evt_unit`

## Requirements
- R1: After reset, the event register reads 0x00 and irq_o is 0.
- R2: A pulse on rx_brk_i sets event bit 4, and a pulse on rx_ctl_i sets event bit 3. Each bit is visible from the cycle after the pulse.
- R3: At a rx_stop_mid_i strobe with rx_buf_ready_i low, event bit 2 (busy) is set. The character is dropped, so bit 0 is not set by that strobe.
- R4: Event bit 0 (receive buffer done) is set only at a rx_stop_mid_i strobe with rx_buf_ready_i and rx_close_i both high. rx_close_i alone sets nothing.
- R5: rx_hunt_o is high in the same cycle as a busy detection, and only when multidrop_i is high.
- R6: A tx_done_i pulse with tx_cr_i low sets event bit 1 (transmit buffer done).
- R7: A tx_done_i pulse with tx_cr_i high does not set bit 1 by itself. Bit 1 is set at the first later tx_last_bit_i strobe that comes while tx_fifo_empty_i is high. A strobe while the FIFO is not empty does nothing.
- R8: Event bits are sticky. A write to address 0 clears each bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R9: If an event's set and its write-one clear fall in the same cycle, the bit ends at 1.
- R10: The mask register is at address 1, is 8 bits wide, is read/write and resets to 0x00. Event bits 7 to 5 always read 0.
- R11: irq_o is the OR of all bits of (event AND mask), taken from the registered values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_brk_i | input | 1 | Break detected pulse |
| rx_ctl_i | input | 1 | Control character captured pulse |
| rx_stop_mid_i | input | 1 | Strobe at the middle of the current character's stop bit |
| rx_buf_ready_i | input | 1 | A receive buffer is available |
| rx_close_i | input | 1 | The current character closes its buffer |
| multidrop_i | input | 1 | Multidrop mode is active |
| rx_hunt_o | output | 1 | Request to return the receiver to hunt mode |
| tx_done_i | input | 1 | Final character of the buffer written to the transmit FIFO |
| tx_cr_i | input | 1 | Per-buffer deferred-completion mode, sampled with tx_done_i |
| tx_last_bit_i | input | 1 | Strobe at the start of a character's last data bit |
| tx_fifo_empty_i | input | 1 | Transmit FIFO holds no characters |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 for events, 1 for mask |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
The key collision is between an event being raised and software clearing the same bit. To provoke it, the bench writes the event register with ones in the same cycle as a break pulse. It also does this at random while break, control, busy and transmit events are firing. A bench model gives set priority over clear, and every cycle the readback and irq_o are compared against it. A second overlap is also checked: a deferred transmit completion firing in the same cycle that a new deferred buffer is armed.

// File: rtl/uef_pkg.sv
package uef_pkg;
  parameter int REG_W  = 8;
  parameter int NUM_EV = 5;
  localparam int EV_RXD = 0;
  localparam int EV_TXD = 1;
  localparam int EV_BSY = 2;
  localparam int EV_CTL = 3;
  localparam int EV_BRK = 4;
  typedef logic [REG_W-1:0]  reg_t;
  typedef logic [NUM_EV-1:0] ev_t;
endpackage

// File: rtl/uef_rx_timing.sv
module uef_rx_timing (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_mid_i,
  input  logic buf_ready_i,
  input  logic close_i,
  input  logic multidrop_i,
  output logic busy_o,
  output logic rxd_o,
  output logic hunt_o
);
  // decisions only at the mid-stop-bit point
  always_comb begin
    busy_o = stop_mid_i & ~buf_ready_i;
    rxd_o  = stop_mid_i & buf_ready_i & close_i;
    hunt_o = busy_o & multidrop_i;
  end

  a_r3_drop_no_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_mid_i && !buf_ready_i) |-> (busy_o && !rxd_o));
  a_r4_close_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_mid_i) |-> !rxd_o);
  a_r5_hunt_multidrop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_o |-> (multidrop_i && !buf_ready_i));
endmodule

// File: rtl/uef_tx_timing.sv
module uef_tx_timing (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic cr_i,
  input  logic last_bit_i,
  input  logic fifo_empty_i,
  output logic set_o
);
  logic pend_q;
  logic fire;

  // deferred completion: final char in shifter, last data bit starting
  assign fire  = pend_q & last_bit_i & fifo_empty_i;
  assign set_o = (done_i & ~cr_i) | fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_q <= 1'b0;
    else if (done_i && cr_i)  pend_q <= 1'b1;
    else if (fire)            pend_q <= 1'b0;
  end

  a_r6_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !cr_i) |-> set_o);
  a_r7_deferred_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && cr_i && !(last_bit_i && fifo_empty_i)) |-> !set_o);
  a_r7_busy_fifo_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_empty_i && !(done_i && !cr_i)) |-> !set_o);
endmodule

// File: rtl/uef_event_reg.sv
module uef_event_reg
  import uef_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ev_t  set_i,
  input  logic we_i,
  input  logic addr_i,
  input  reg_t wdata_i,
  output reg_t rdata_o,
  output logic irq_o
);
  ev_t  evt_q;
  ev_t  clr;
  reg_t mask_q;
  reg_t evt_full;

  assign clr = (we_i && !addr_i) ? wdata_i[NUM_EV-1:0] : '0;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
    // set wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        evt_q[i] <= 1'b0;
      else if (set_i[i])  evt_q[i] <= 1'b1;
      else if (clr[i])    evt_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              mask_q <= '0;
    else if (we_i && addr_i)  mask_q <= wdata_i;
  end

  assign evt_full = reg_t'(evt_q);
  assign rdata_o  = addr_i ? mask_q : evt_full;
  assign irq_o    = |(evt_full & mask_q);

  a_r8_clear_applies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i) |=> ((evt_q & $past(wdata_i[NUM_EV-1:0] & ~set_i)) == '0));
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((evt_q & $past(set_i)) == $past(set_i)));
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && !addr_i) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
  a_r11_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0 && evt_q != '0));
endmodule

// File: rtl/uart_evt_unit.sv
module uart_evt_unit
  import uef_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_brk_i,
  input  logic             rx_ctl_i,
  input  logic             rx_stop_mid_i,
  input  logic             rx_buf_ready_i,
  input  logic             rx_close_i,
  input  logic             multidrop_i,
  output logic             rx_hunt_o,
  input  logic             tx_done_i,
  input  logic             tx_cr_i,
  input  logic             tx_last_bit_i,
  input  logic             tx_fifo_empty_i,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  logic busy, rxd, txd;
  ev_t  set_vec;

  uef_rx_timing u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .stop_mid_i(rx_stop_mid_i), .buf_ready_i(rx_buf_ready_i),
    .close_i(rx_close_i), .multidrop_i(multidrop_i),
    .busy_o(busy), .rxd_o(rxd), .hunt_o(rx_hunt_o)
  );

  uef_tx_timing u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .done_i(tx_done_i), .cr_i(tx_cr_i),
    .last_bit_i(tx_last_bit_i), .fifo_empty_i(tx_fifo_empty_i),
    .set_o(txd)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[EV_RXD] = rxd;
    set_vec[EV_TXD] = txd;
    set_vec[EV_BSY] = busy;
    set_vec[EV_CTL] = rx_ctl_i;
    set_vec[EV_BRK] = rx_brk_i;
  end

  uef_event_reg u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_vec),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  a_r2_break_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_brk_i |=> (reg_addr_i || reg_rdata_o[EV_BRK]));
  a_r10_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_addr_i |-> (reg_rdata_o[REG_W-1:NUM_EV] == '0));
endmodule

// File: tb/tb_uart_evt_unit.sv
module tb_uart_evt_unit;
  typedef struct packed {
    logic brk, ctl, stop_mid, ready, close, md;
    logic done, cr, last_bit, fempty;
    logic we, addr;
    logic [7:0] wdata;
  } stim_t;

  logic clk = 0, rst_ni = 0;
  logic rx_brk, rx_ctl, rx_stop_mid, rx_buf_ready, rx_close, multidrop;
  logic tx_done, tx_cr, tx_last_bit, tx_fifo_empty, reg_we, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic rx_hunt, irq;

  int checks = 0, fails = 0;
  logic [4:0] m_evt = '0;
  logic [7:0] m_mask = '0;
  logic m_pend = 0;

  always #2.5 clk = ~clk;

  uart_evt_unit dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rx_brk_i(rx_brk), .rx_ctl_i(rx_ctl), .rx_stop_mid_i(rx_stop_mid),
    .rx_buf_ready_i(rx_buf_ready), .rx_close_i(rx_close), .multidrop_i(multidrop),
    .rx_hunt_o(rx_hunt), .tx_done_i(tx_done), .tx_cr_i(tx_cr),
    .tx_last_bit_i(tx_last_bit), .tx_fifo_empty_i(tx_fifo_empty),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  function automatic stim_t idle();
    stim_t s = '0;
    s.ready = 1; s.fempty = 1;
    return s;
  endfunction

  function automatic logic [4:0] set_of(stim_t s, logic pend);
    logic [4:0] v = '0;
    v[4] = s.brk;
    v[3] = s.ctl;
    v[2] = s.stop_mid & ~s.ready;
    v[0] = s.stop_mid & s.ready & s.close;
    v[1] = (s.done & ~s.cr) | (pend & s.last_bit & s.fempty);
    return v;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic apply(input stim_t s);
    {rx_brk, rx_ctl, rx_stop_mid, rx_buf_ready, rx_close, multidrop} =
      {s.brk, s.ctl, s.stop_mid, s.ready, s.close, s.md};
    {tx_done, tx_cr, tx_last_bit, tx_fifo_empty} = {s.done, s.cr, s.last_bit, s.fempty};
    {reg_we, reg_addr, reg_wdata} = {s.we, s.addr, s.wdata};
  endtask

  // one cycle: drive at negedge, model the edge, check at next negedge
  task automatic cycle(input stim_t s, input string tag);
    logic [4:0] st;
    logic fire;
    apply(s);
    #1;
    check({tag, "/R5 hunt"}, {7'd0, rx_hunt}, {7'd0, s.stop_mid & ~s.ready & s.md});
    @(posedge clk);
    st = set_of(s, m_pend);
    fire = m_pend & s.last_bit & s.fempty;
    if (s.done && s.cr) m_pend = 1;
    else if (fire) m_pend = 0;
    if (s.we && !s.addr) m_evt = (m_evt & ~s.wdata[4:0]) | st;
    else m_evt = m_evt | st;
    if (s.we && s.addr) m_mask = s.wdata;
    @(negedge clk);
    check({tag, "/R11 irq"}, {7'd0, irq}, {7'd0, |({3'b0, m_evt} & m_mask)});
    check({tag, " rdata"}, reg_rdata, s.addr ? m_mask : {3'b0, m_evt});
  endtask

  task automatic rd(input logic a, input string tag, input logic [7:0] exp);
    stim_t s = idle();
    s.addr = a;
    cycle(s, tag);
    check({tag, " literal"}, reg_rdata, exp);
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input string tag);
    stim_t s = idle();
    s.we = 1; s.addr = a; s.wdata = d;
    cycle(s, tag);
  endtask

  initial begin
    int limit = 100000;
    repeat (limit) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    stim_t s;
    void'($urandom(32'h1d2c3b4a));
    apply(idle());
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 / R10 reset state
    check("R1 irq reset", {7'd0, irq}, 8'h00);
    rd(0, "R1", 8'h00);
    rd(1, "R10", 8'h00);
    wr(1, 8'hFF, "R10");
    rd(1, "R10", 8'hFF);
    // R2 break and control character
    s = idle(); s.brk = 1; cycle(s, "R2");
    rd(0, "R2", 8'h10);
    s = idle(); s.ctl = 1; cycle(s, "R2");
    rd(0, "R2", 8'h18);
    // R8 write 1 clears, write 0 no effect
    wr(0, 8'h08, "R8");
    rd(0, "R8", 8'h10);
    wr(0, 8'h00, "R8");
    rd(0, "R8", 8'h10);
    // R9 set and clear same cycle
    s = idle(); s.brk = 1; s.we = 1; s.wdata = 8'h10; cycle(s, "R9");
    rd(0, "R9", 8'h10);
    wr(0, 8'hFF, "R8");
    rd(0, "R8", 8'h00);
    // R3 / R5 busy with and without multidrop
    s = idle(); s.stop_mid = 1; s.ready = 0; s.close = 1; s.md = 1; cycle(s, "R3");
    rd(0, "R3", 8'h04);
    s = idle(); s.stop_mid = 1; s.ready = 0; s.md = 0; cycle(s, "R5");
    wr(0, 8'hFF, "R3");
    // R4 close alone does nothing, strobe closes
    s = idle(); s.close = 1; cycle(s, "R4");
    rd(0, "R4", 8'h00);
    s = idle(); s.close = 1; s.stop_mid = 1; cycle(s, "R4");
    rd(0, "R4", 8'h01);
    wr(0, 8'hFF, "R4");
    // R6 immediate transmit completion
    s = idle(); s.done = 1; cycle(s, "R6");
    rd(0, "R6", 8'h02);
    wr(0, 8'hFF, "R6");
    // R7 deferred transmit completion
    s = idle(); s.done = 1; s.cr = 1; cycle(s, "R7");
    rd(0, "R7", 8'h00);
    s = idle(); s.last_bit = 1; s.fempty = 0; cycle(s, "R7");
    rd(0, "R7", 8'h00);
    s = idle(); s.last_bit = 1; cycle(s, "R7");
    rd(0, "R7", 8'h02);
    s = idle(); s.last_bit = 1; s.we = 1; s.wdata = 8'h02; cycle(s, "R7");
    rd(0, "R7", 8'h00);
    // R11 masked events do not interrupt
    wr(1, 8'h00, "R11");
    s = idle(); s.brk = 1; s.ctl = 1; cycle(s, "R11");
    check("R11 masked", {7'd0, irq}, 8'h00);
    wr(1, 8'h08, "R11");
    check("R11 unmasked", {7'd0, irq}, 8'h01);
    // R10 reserved bits of event register read zero
    wr(0, 8'hE0, "R10");
    rd(0, "R10", 8'h18);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      s = idle();
      s.brk = ($urandom % 10) == 0;
      s.ctl = ($urandom % 10) == 0;
      s.stop_mid = ($urandom % 4) == 0;
      s.ready = ($urandom % 3) != 0;
      s.close = $urandom % 2;
      s.md = $urandom % 2;
      s.done = ($urandom % 8) == 0;
      s.cr = $urandom % 2;
      s.last_bit = ($urandom % 4) == 0;
      s.fempty = $urandom % 2;
      s.we = ($urandom % 3) == 0;
      s.addr = $urandom % 2;
      s.wdata = 8'($urandom);
      cycle(s, "R9 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule